// File: doc/BRIEF.md
# DMA Channel Result and Interrupt Unit

This unit collects completion reports from the sixteen channel engines of a DMA controller and raises one interrupt line for all of them. When an engine finishes a transfer, it presents a 32-bit result word. The unit stores that word in the channel's single result slot and marks the slot as available. Software services the interrupt in three steps. It reads the summary register to find the channels that need attention. It reads a channel's status register to confirm that a result is waiting. It then reads the result register, and that read empties the slot.

Each channel has a small configuration register with two enables. One enable allows the channel to assert the interrupt. The other allows results that report a flush to be stored.

Each channel also has a write-only abort command. Writing to it sends a one-cycle abort request to the channel's engine. The next result that arrives from that engine is then marked as flushed.

Top module: `dmares_unit`

## Requirements
- R1: After reset, every result slot is empty and every configuration register is zero. `irq` and `flush_req` are low, and all register reads return zero.
- R2: Register address `reg_addr` is {kind[2:0], channel[3:0]}. The kind values are: 0 = result, 1 = status, 2 = configuration, 3 = abort command, 4 = summary (the channel field is ignored for the summary). An engine event whose word has bit 31 set is stored in the slot of that channel. Status bit 1 then reads 1, and a result read returns the stored word unchanged, including error bit 3.
- R3: An engine event whose word has bit 31 clear is ignored. The slot, the status register and `irq` do not change.
- R4: A result read returns the stored word and empties the slot. After it, status bits 1 and 2 and the channel's summary bit read 0. A result read of an empty slot returns 0.
- R5: An event that arrives while the slot is already full is discarded. The first word is kept, and status bit 2 (overflow) is set and stays set until the next result read.
- R6: Summary bit i reads 1 only while channel i holds a result and its configuration bit 0 (interrupt enable) is 1. `irq` is the OR of all summary bits. Writing 0 to the configuration masks the channel. Enabling it again while a result is held raises `irq`.
- R7: A configuration write stores `reg_wdata[1:0]`, and a configuration read returns those two bits in bits 1:0.
- R8: Any write to a channel's abort command drives that channel's `flush_req` high for exactly one cycle, in the cycle after the write.
- R9: The first event with bit 31 set that arrives after an abort command is stored with bit 2 (flushed) set and bit 1 (transfer done) cleared. Events after that one are stored unchanged.
- R10: When configuration bit 1 (flush-report enable) is 0, any event whose stored form would have bit 2 set is dropped, and the slot stays as it was.
- R11: Channels are independent. Events, reads and commands on one channel change no other channel's slot, status or summary bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_vld | input | NCH | Per-channel event strobe from the engines |
| ev_word | input | 32*NCH | Per-channel result words, channel i at bits [32*i+31:32*i] |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (result reads pop) |
| reg_addr | input | 3+clog2(NCH) | {kind, channel} register address |
| reg_wdata | input | 2 | Configuration write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| flush_req | output | NCH | One-cycle abort request to each engine |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the unit with the default of sixteen channels. With that setting the channel field is four bits wide and the summary register fills bits 15:0. Tests on channel 0 and channel 15 therefore reach both ends of the address decode and of the summary vector. Channels are spread across the scenarios, so the bench can show that activity on one channel leaves the summary bits of the others unchanged.

// File: rtl/dmares_pkg.sv
// Shared field positions and register kinds for the DMA result unit.
// Assumes a 32-bit result word and a two-bit channel configuration.
package dmares_pkg;
    localparam int WORD_W   = 32;
    localparam int RB_VALID = 31;
    localparam int RB_ERR   = 3;
    localparam int RB_FLUSH = 2;
    localparam int RB_TPD   = 1;
    localparam int SB_AVAIL = 1;
    localparam int SB_OVF   = 2;
    localparam int CB_IEN   = 0;
    localparam int CB_FEN   = 1;
    localparam int CFG_W    = 2;
    localparam int KIND_W   = 3;

    typedef enum logic [KIND_W-1:0] {
        K_RESULT  = 3'd0,
        K_STATUS  = 3'd1,
        K_CONFIG  = 3'd2,
        K_FLUSH   = 3'd3,
        K_SUMMARY = 3'd4
    } reg_kind_e;
endpackage

// File: rtl/dmares_slot.sv
// One channel's result slot: holds one result word, the overflow flag,
// the channel configuration and the pending-abort marker.
// Assumes at most one strobe from the register decoder per cycle.
module dmares_slot
    import dmares_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_vld,
    input  logic [WORD_W-1:0] ev_word,
    input  logic              res_rd,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              flush_wr,
    output logic [WORD_W-1:0] res_word,
    output logic              res_vld,
    output logic              ovf,
    output logic [CFG_W-1:0]  cfg,
    output logic              flush_req,
    output logic              sum_bit
);
    logic [WORD_W-1:0] held;
    logic [WORD_W-1:0] eff_word;
    logic              pend;
    logic              take;
    logic              keep;
    logic              room;

    // Qualify the incoming event and mark it flushed if an abort is pending.
    always_comb begin
        take     = ev_vld & ev_word[RB_VALID];
        eff_word = ev_word;
        if (pend) begin
            eff_word[RB_FLUSH] = 1'b1;
            eff_word[RB_TPD]   = 1'b0;
        end
        keep = take & (~eff_word[RB_FLUSH] | cfg[CB_FEN]);
        room = ~res_vld | res_rd;
    end

    // Result slot: store when there is room, flag overflow otherwise, empty on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held    <= '0;
            res_vld <= 1'b0;
            ovf     <= 1'b0;
        end else if (keep && room) begin
            held    <= eff_word;
            res_vld <= 1'b1;
            ovf     <= 1'b0;
        end else if (keep) begin
            ovf     <= 1'b1;
        end else if (res_rd) begin
            held    <= '0;
            res_vld <= 1'b0;
            ovf     <= 1'b0;
        end
    end

    // Channel configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (cfg_wr) cfg <= cfg_wdata;
    end

    // Abort request pulse and pending marker for the next result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            flush_req <= 1'b0;
        end else begin
            pend      <= flush_wr | (pend & ~take);
            flush_req <= flush_wr;
        end
    end

    assign res_word = held;
    assign sum_bit  = res_vld & cfg[CB_IEN];

    a_r5_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld && !res_rd && keep |=> ovf && res_vld && res_word == $past(res_word));
    a_r4_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
        res_rd && !keep |=> !res_vld && !ovf);
    a_r3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vld && !ev_word[RB_VALID] && !res_rd |=> $stable(res_vld) && $stable(res_word));
    a_r8_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> flush_req);
    a_r9_flush_marked: assert property (@(posedge clk) disable iff (!rst_n)
        pend && keep && room |=> res_word[RB_FLUSH] && !res_word[RB_TPD]);
endmodule

// File: rtl/dmares_regif.sv
// Register decoder and read mux for the result unit.
// Address is {kind, channel}; result reads pop; read data is combinational.
// Assumes NCH <= 32 so that the summary fits the read word.
module dmares_regif
    import dmares_pkg::*;
#(
    parameter  int NCH = 16,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = CHW + KIND_W
) (
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [AW-1:0]         reg_addr,
    input  logic [NCH*WORD_W-1:0] res_words,
    input  logic [NCH-1:0]        res_vld,
    input  logic [NCH-1:0]        ovf,
    input  logic [NCH*CFG_W-1:0]  cfgs,
    input  logic [NCH-1:0]        sum_bits,
    output logic [NCH-1:0]        res_rd,
    output logic [NCH-1:0]        cfg_wr,
    output logic [NCH-1:0]        flush_wr,
    output logic [WORD_W-1:0]     rdata
);
    reg_kind_e       kind;
    logic [CHW-1:0]  ch;
    logic            ch_ok;

    assign kind  = reg_kind_e'(reg_addr[AW-1:CHW]);
    assign ch    = reg_addr[CHW-1:0];
    assign ch_ok = (int'(ch) < NCH);

    // Per-channel strobes from the decoded address.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            res_rd[i]   = reg_rd && kind == K_RESULT && ch == CHW'(i);
            cfg_wr[i]   = reg_wr && kind == K_CONFIG && ch == CHW'(i);
            flush_wr[i] = reg_wr && kind == K_FLUSH  && ch == CHW'(i);
        end
    end

    // Read data selection by kind.
    always_comb begin
        rdata = '0;
        if (reg_rd) begin
            case (kind)
                K_RESULT:  if (ch_ok) rdata = res_words[int'(ch)*WORD_W +: WORD_W];
                K_STATUS:  if (ch_ok) begin
                    rdata[SB_AVAIL] = res_vld[ch];
                    rdata[SB_OVF]   = ovf[ch];
                end
                K_CONFIG:  if (ch_ok) rdata[CFG_W-1:0] = cfgs[int'(ch)*CFG_W +: CFG_W];
                K_SUMMARY: rdata[NCH-1:0] = sum_bits;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dmares_unit.sv
// Top of the DMA channel result and interrupt unit: one slot per channel,
// a shared register decoder and the combined interrupt.
// Assumes engines hold ev_word stable while ev_vld is high.
module dmares_unit
    import dmares_pkg::*;
#(
    parameter  int NCH = 16,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = CHW + KIND_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        ev_vld,
    input  logic [NCH*WORD_W-1:0] ev_word,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [AW-1:0]         reg_addr,
    input  logic [CFG_W-1:0]      reg_wdata,
    output logic [WORD_W-1:0]     reg_rdata,
    output logic [NCH-1:0]        flush_req,
    output logic                  irq
);
    logic [NCH*WORD_W-1:0] res_words;
    logic [NCH-1:0]        res_vld;
    logic [NCH-1:0]        ovf;
    logic [NCH*CFG_W-1:0]  cfgs;
    logic [NCH-1:0]        sum_bits;
    logic [NCH-1:0]        res_rd;
    logic [NCH-1:0]        cfg_wr;
    logic [NCH-1:0]        flush_wr;

    dmares_regif #(.NCH(NCH)) u_regif (
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .res_words (res_words),
        .res_vld   (res_vld),
        .ovf       (ovf),
        .cfgs      (cfgs),
        .sum_bits  (sum_bits),
        .res_rd    (res_rd),
        .cfg_wr    (cfg_wr),
        .flush_wr  (flush_wr),
        .rdata     (reg_rdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        dmares_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev_vld    (ev_vld[g]),
            .ev_word   (ev_word[g*WORD_W +: WORD_W]),
            .res_rd    (res_rd[g]),
            .cfg_wr    (cfg_wr[g]),
            .cfg_wdata (reg_wdata),
            .flush_wr  (flush_wr[g]),
            .res_word  (res_words[g*WORD_W +: WORD_W]),
            .res_vld   (res_vld[g]),
            .ovf       (ovf[g]),
            .cfg       (cfgs[g*CFG_W +: CFG_W]),
            .flush_req (flush_req[g]),
            .sum_bit   (sum_bits[g])
        );
    end

    // Combined interrupt from all qualified summary bits.
    assign irq = |sum_bits;

    a_r6_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|res_vld));
    a_r11_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_rd));
endmodule

// File: tb/dmares_unit_test.sv
module dmares_unit_test;
    localparam int NCH = 16;
    localparam int W   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  ev_vld = '0;
    logic [NCH*W-1:0] ev_word = '0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [6:0]      reg_addr = '0;
    logic [1:0]      reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NCH-1:0]  flush_req;
    logic            irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dmares_unit #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_word(ev_word),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flush_req(flush_req), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic wr(input logic [2:0] kind, input int ch, input logic [1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {kind, 4'(ch)}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] kind, input int ch, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = {kind, 4'(ch)};
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic post(input int ch, input logic [31:0] w);
        @(negedge clk);
        ev_vld[ch] = 1'b1; ev_word[ch*W +: W] = w;
        @(negedge clk);
        ev_vld[ch] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 flush_req", {16'd0, flush_req}, 0);
        rd(3'd4, 0, v);  check("R1 summary", v, 0);
        rd(3'd1, 5, v);  check("R1 status", v, 0);
        rd(3'd2, 5, v);  check("R1 config", v, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        wr(3'd2, 3, 2'd3);
        rd(3'd2, 3, v);  check("R7 config readback", v, 3);
        post(3, 32'h8000_0002);
        rd(3'd1, 3, v);  check("R2 status avail", v, 32'h2);
        rd(3'd4, 0, v);  check("R6 summary bit3", v, 32'h8);
        check("R6 irq high", {31'd0, irq}, 1);
        rd(3'd0, 3, v);  check("R2 result word", v, 32'h8000_0002);
        rd(3'd1, 3, v);  check("R4 status cleared", v, 0);
        rd(3'd4, 0, v);  check("R4 summary cleared", v, 0);
        check("R4 irq low", {31'd0, irq}, 0);
        rd(3'd0, 3, v);  check("R4 empty read", v, 0);
    endtask

    task automatic t_error();
        logic [31:0] v;
        wr(3'd2, 5, 2'd1);
        post(5, 32'h8000_000A);
        rd(3'd0, 5, v);  check("R2 error bit kept", v, 32'h8000_000A);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        post(3, 32'h0000_0002);
        rd(3'd1, 3, v);  check("R3 status unchanged", v, 0);
        check("R3 irq low", {31'd0, irq}, 0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        wr(3'd2, 7, 2'd1);
        post(7, 32'h8000_0002);
        post(7, 32'h8000_0008);
        rd(3'd1, 7, v);  check("R5 overflow status", v, 32'h6);
        rd(3'd0, 7, v);  check("R5 first kept", v, 32'h8000_0002);
        rd(3'd1, 7, v);  check("R5 overflow cleared", v, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(3'd2, 9, 2'd0);
        post(9, 32'h8000_0002);
        rd(3'd1, 9, v);  check("R6 masked held", v, 32'h2);
        rd(3'd4, 0, v);  check("R6 masked summary", v, 0);
        check("R6 masked irq", {31'd0, irq}, 0);
        wr(3'd2, 9, 2'd1);
        check("R6 unmask irq", {31'd0, irq}, 1);
        rd(3'd4, 0, v);  check("R6 unmask summary", v, 32'h200);
        rd(3'd0, 9, v);  check("R6 masked word", v, 32'h8000_0002);
        check("R6 irq after pop", {31'd0, irq}, 0);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        wr(3'd2, 11, 2'd3);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {3'd3, 4'd11};
        check("R8 no early pulse", {16'd0, flush_req}, 0);
        @(negedge clk);
        reg_wr = 1'b0;
        check("R8 pulse", {16'd0, flush_req}, 32'h800);
        @(negedge clk);
        check("R8 pulse ends", {16'd0, flush_req}, 0);
        post(11, 32'h8000_0002);
        rd(3'd0, 11, v); check("R9 flushed word", v, 32'h8000_0004);
        post(11, 32'h8000_0002);
        rd(3'd0, 11, v); check("R9 next unchanged", v, 32'h8000_0002);
    endtask

    task automatic t_flush_drop();
        logic [31:0] v;
        wr(3'd2, 12, 2'd1);
        wr(3'd3, 12, 2'd0);
        post(12, 32'h8000_0002);
        rd(3'd1, 12, v); check("R10 abort result dropped", v, 0);
        post(12, 32'h8000_0004);
        rd(3'd1, 12, v); check("R10 flushed event dropped", v, 0);
        post(12, 32'h8000_0002);
        rd(3'd0, 12, v); check("R10 normal still stored", v, 32'h8000_0002);
    endtask

    task automatic t_multi();
        logic [31:0] v;
        wr(3'd2, 0, 2'd1);
        wr(3'd2, 15, 2'd1);
        post(0, 32'h8000_0002);
        post(15, 32'h8000_0008);
        rd(3'd4, 0, v);  check("R11 both summary", v, 32'h8001);
        rd(3'd0, 0, v);  check("R11 ch0 word", v, 32'h8000_0002);
        rd(3'd4, 0, v);  check("R11 ch15 remains", v, 32'h8000);
        rd(3'd1, 15, v); check("R11 ch15 status", v, 32'h2);
        rd(3'd0, 15, v); check("R11 ch15 word", v, 32'h8000_0008);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_error();
        t_ignored();
        t_overflow();
        t_mask();
        t_flush();
        t_flush_drop();
        t_multi();
        summary_and_end();
    end
endmodule